// File: doc/BRIEF.md
# Three-Port GPIO with Sleep Pad States

This block drives and samples 20 general-purpose pins split into three ports: port A with 4 pins and ports B and C with 8 pins each. For every port, software programs a direction word and an output word that set the pads in normal operation, plus a second direction word and output word that set the pads while the device sleeps. When the `sleep_i` input is high, the pads switch to the sleep pair on their own. No software action is needed at the moment of entering or leaving sleep.

Software reaches all registers over a single-cycle register bus. Writes land on the clock edge on which `bus_we` is high. Reads are combinational from `bus_addr`. Each pin's input level passes through a two-flop synchronizer and can be read back as its own register. Drivers update single bits by reading a whole word, changing it under a mask and writing it back, so every register is readable and writable as a full word.

The pads appear as one packed 24-bit view with port A in bits 3:0, port B in bits 15:8 and port C in bits 23:16. Bits 7:4 of the view carry no pin.

Top module: `gpio3_sleep`

## Requirements
- R1: After reset, all direction, sleep-direction, output and sleep-output registers read 0, and `pad_oe` and `pad_out` are 0.
- R2: `bus_addr[4:3]` selects the port (0 = A, 1 = B, 2 = C). `bus_addr[2:0]` selects the register: 0 direction, 1 output, 2 sleep direction, 3 sleep output, 4 pin input. A full-word write is read back unchanged starting the cycle after the write edge.
- R3: Port A keeps only the low 4 bits of a written word. Bits 7:4 of any port A read are 0.
- R4: While `sleep_i` is 0, each port's `pad_oe` lane equals its direction register (1 = output, 0 = input), and its `pad_out` lane equals its output register.
- R5: While `sleep_i` is 1, each port's `pad_oe` lane equals its sleep-direction register and its `pad_out` lane equals its sleep-output register. The switch happens in the same cycle as `sleep_i` changes.
- R6: Reading the pin-input register returns the value `pad_in` had two rising clock edges earlier. A change on `pad_in` is not visible after only one edge.
- R7: A write to the pin-input register, to register codes 5 to 7, or to port code 3 changes no register and no pad. A read of port code 3 returns 0.
- R8: Bits 7:4 of `pad_oe` and `pad_out` are always 0. `pad_in[7:4]` never shows up in a read.
- R9: Raising and lowering `sleep_i` leaves all register contents unchanged. The normal pad values return when `sleep_i` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Sleep request; selects the sleep pad registers |
| bus_addr | input | 5 | Register address: port in bits 4:3, register in bits 2:0 |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pad_in | input | 24 | Packed pin input levels |
| pad_oe | output | 24 | Packed pad output enables |
| pad_out | output | 24 | Packed pad output values |

## Verification
Each port's four writable registers get a different asymmetric byte pattern, so a swapped port, a swapped register or a misplaced lane produces a visible mismatch. Port A is written with nonzero upper nibbles to show that it truncates to 4 bits. The pads are compared against the whole packed expectation with sleep low and then high, and again after sleep falls, which shows the two register sets are kept apart. A step on `pad_in` is read before the first edge, after one edge and after two, which pins down the synchronizer depth. Writes to the read-only, unused and out-of-range addresses are each followed by a full readback and a pad comparison.

// File: rtl/gpio3_pkg.sv
package gpio3_pkg;
   localparam int NPORT  = 3;
   localparam int PORT_W = 2;
   localparam int SEL_W  = 3;

   typedef enum logic [SEL_W-1:0] {
      REG_DIR  = 3'd0,
      REG_OUT  = 3'd1,
      REG_SDIR = 3'd2,
      REG_SOUT = 3'd3,
      REG_PIN  = 3'd4
   } gpio_reg_e;
endpackage

// File: rtl/gpio3_sync.sv
module gpio3_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio3_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio3_port.sv
module gpio3_port
   import gpio3_pkg::*;
#(
   parameter int W    = 8,
   parameter int DW   = 8,
   parameter int SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep_i,
   input  logic          wr_en,
   input  gpio_reg_e     sel_i,
   input  logic [DW-1:0] wr_data,
   input  logic [DW-1:0] pin_i,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] oe_o,
   output logic [DW-1:0] out_o
);
   logic [W-1:0] dir_q, out_q, sdir_q, sout_q, pin_s;

   generate
      if (W < DW) begin : g_narrow
         logic unused_hi;
         assign unused_hi = ^{pin_i[DW-1:W], wr_data[DW-1:W]};
      end
   endgenerate

   gpio3_sync #(.W(W), .STAGES(SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i[W-1:0]),
      .q_o   (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         sdir_q <= '0;
         sout_q <= '0;
      end else if (wr_en) begin
         case (sel_i)
            REG_DIR:  dir_q  <= wr_data[W-1:0];
            REG_OUT:  out_q  <= wr_data[W-1:0];
            REG_SDIR: sdir_q <= wr_data[W-1:0];
            REG_SOUT: sout_q <= wr_data[W-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (sel_i)
         REG_DIR:  rd_data[W-1:0] = dir_q;
         REG_OUT:  rd_data[W-1:0] = out_q;
         REG_SDIR: rd_data[W-1:0] = sdir_q;
         REG_SOUT: rd_data[W-1:0] = sout_q;
         REG_PIN:  rd_data[W-1:0] = pin_s;
         default:  rd_data = '0;
      endcase
   end

   always_comb begin
      oe_o  = '0;
      out_o = '0;
      oe_o[W-1:0]  = sleep_i ? sdir_q : dir_q;
      out_o[W-1:0] = sleep_i ? sout_q : out_q;
   end
endmodule

// File: rtl/gpio3_sleep.sv
module gpio3_sleep
   import gpio3_pkg::*;
#(
   parameter  int PA_W  = 4,
   parameter  int PB_W  = 8,
   parameter  int PC_W  = 8,
   parameter  int DW    = 8,
   parameter  int SYNC  = 2,
   localparam int AW    = PORT_W + SEL_W,
   localparam int PAD_W = NPORT * DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_i,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_we,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [PAD_W-1:0] pad_in,
   output logic [PAD_W-1:0] pad_oe,
   output logic [PAD_W-1:0] pad_out
);
   localparam int PW [NPORT] = '{PA_W, PB_W, PC_W};

   generate
      if (PA_W < 1 || PA_W > DW) begin : g_bad_a
         $error("gpio3_sleep: PA_W out of range");
      end
      if (PB_W < 1 || PB_W > DW) begin : g_bad_b
         $error("gpio3_sleep: PB_W out of range");
      end
      if (PC_W < 1 || PC_W > DW) begin : g_bad_c
         $error("gpio3_sleep: PC_W out of range");
      end
   endgenerate

   logic [PORT_W-1:0]          port_idx;
   gpio_reg_e                  reg_sel;
   logic [NPORT-1:0][DW-1:0]   lane_rd, lane_oe, lane_out;

   assign port_idx = bus_addr[AW-1:SEL_W];
   assign reg_sel  = gpio_reg_e'(bus_addr[SEL_W-1:0]);

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_port
         logic wr_hit;
         assign wr_hit = bus_we && (port_idx == PORT_W'(i));
         gpio3_port #(.W(PW[i]), .DW(DW), .SYNC(SYNC)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .sleep_i (sleep_i),
            .wr_en   (wr_hit),
            .sel_i   (reg_sel),
            .wr_data (bus_wdata),
            .pin_i   (pad_in[i*DW +: DW]),
            .rd_data (lane_rd[i]),
            .oe_o    (lane_oe[i]),
            .out_o   (lane_out[i])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int p = 0; p < NPORT; p++) begin
         if (port_idx == PORT_W'(p)) bus_rdata = lane_rd[p];
      end
   end

   assign pad_oe  = lane_oe;
   assign pad_out = lane_out;
endmodule

// File: rtl/gpio3_sleep_chk.sv
module gpio3_sleep_chk #(
   parameter  int PA_W  = 4,
   parameter  int DW    = 8,
   localparam int PAD_W = 3 * DW
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep_i,
   input logic [4:0]       bus_addr,
   input logic             bus_we,
   input logic [DW-1:0]    bus_wdata,
   input logic [DW-1:0]    bus_rdata,
   input logic [PAD_W-1:0] pad_in,
   input logic [PAD_W-1:0] pad_oe,
   input logic [PAD_W-1:0] pad_out
);
   logic [1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   // R3: port A reads never carry bits above its width
   a_r3_porta_width: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[4:3] == 2'd0) |-> (bus_rdata[DW-1:PA_W] == '0));

   // R2, R4: a direction write to port B appears on its output-enable lane
   a_r2_dir_to_pad: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 5'b01_000 && !sleep_i)
      |=> (sleep_i || pad_oe[2*DW-1:DW] == $past(bus_wdata)));

   // R5: steady sleep with no write keeps the pads still
   a_r5_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && $past(sleep_i) && !$past(bus_we))
      |-> ($stable(pad_oe) && $stable(pad_out)));

   // R7: writes to read-only, unused or out-of-range addresses move no pad
   a_r7_noop_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr[2:0] >= 3'd4 || bus_addr[4:3] == 2'd3))
      |=> ((sleep_i != $past(sleep_i)) || ($stable(pad_oe) && $stable(pad_out))));

   // R6: port C pin register shows the input from two edges before
   a_r6_pin_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && bus_addr == 5'b10_100)
      |-> (bus_rdata == $past(pad_in[PAD_W-1:2*DW], 2)));
endmodule

bind gpio3_sleep gpio3_sleep_chk u_chk (.*);

// File: tb/test_gpio3_sleep.sv
module test_gpio3_sleep;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep_i = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [23:0] pad_in = '0;
   logic [23:0] pad_oe, pad_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [23:0] NORM_OE  = 24'hF03C05;
   localparam logic [23:0] NORM_OUT = 24'h0FA50C;
   localparam logic [23:0] SLP_OE   = 24'h81C309;
   localparam logic [23:0] SLP_OUT  = 24'h7E5A06;

   gpio3_sleep i_gpio3_sleep (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
      bus_addr = a;
      #1;
      chk(tag, {16'h0, bus_rdata}, {16'h0, exp});
   endtask

   task automatic chk_all_regs(input string tag);
      rd_chk({tag, " A dir"},  5'd0,  8'h05);
      rd_chk({tag, " A out"},  5'd1,  8'h0C);
      rd_chk({tag, " A sdir"}, 5'd2,  8'h09);
      rd_chk({tag, " A sout"}, 5'd3,  8'h06);
      rd_chk({tag, " B dir"},  5'd8,  8'h3C);
      rd_chk({tag, " B out"},  5'd9,  8'hA5);
      rd_chk({tag, " B sdir"}, 5'd10, 8'hC3);
      rd_chk({tag, " B sout"}, 5'd11, 8'h5A);
      rd_chk({tag, " C dir"},  5'd16, 8'hF0);
      rd_chk({tag, " C out"},  5'd17, 8'h0F);
      rd_chk({tag, " C sdir"}, 5'd18, 8'h81);
      rd_chk({tag, " C sout"}, 5'd19, 8'h7E);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 pad_oe", pad_oe, 24'h0);
      chk("R1 pad_out", pad_out, 24'h0);
      for (int p = 0; p < 3; p++)
         for (int r = 0; r < 4; r++)
            rd_chk("R1 reg", 5'(p * 8 + r), 8'h00);
   endtask

   task automatic t_regs();
      wr(5'd0, 8'hA5);  wr(5'd1, 8'h3C);  wr(5'd2, 8'hF9);  wr(5'd3, 8'h06);
      wr(5'd8, 8'h3C);  wr(5'd9, 8'hA5);  wr(5'd10, 8'hC3); wr(5'd11, 8'h5A);
      wr(5'd16, 8'hF0); wr(5'd17, 8'h0F); wr(5'd18, 8'h81); wr(5'd19, 8'h7E);
      chk_all_regs("R2 R3 readback");
   endtask

   task automatic t_normal();
      sleep_i = 1'b0;
      #1;
      chk("R4 R8 normal oe", pad_oe, NORM_OE);
      chk("R4 R8 normal out", pad_out, NORM_OUT);
   endtask

   task automatic t_sleep();
      @(negedge clk);
      sleep_i = 1'b1;
      #1;
      chk("R5 sleep oe", pad_oe, SLP_OE);
      chk("R5 sleep out", pad_out, SLP_OUT);
      repeat (3) @(negedge clk);
      chk("R5 sleep oe held", pad_oe, SLP_OE);
      sleep_i = 1'b0;
      #1;
      chk("R9 wake oe", pad_oe, NORM_OE);
      chk("R9 wake out", pad_out, NORM_OUT);
      chk_all_regs("R9 after sleep");
   endtask

   task automatic t_sync();
      @(negedge clk);
      pad_in = 24'hA55AF3;
      rd_chk("R6 before edge", 5'd20, 8'h00);
      @(negedge clk);
      rd_chk("R6 one edge", 5'd20, 8'h00);
      @(negedge clk);
      rd_chk("R6 two edges C", 5'd20, 8'hA5);
      rd_chk("R6 two edges B", 5'd12, 8'h5A);
      rd_chk("R3 R8 pin A", 5'd4, 8'h03);
   endtask

   task automatic t_ignore();
      wr(5'd4, 8'hFF);  wr(5'd12, 8'hFF); wr(5'd20, 8'hFF);
      wr(5'd13, 8'hFF); wr(5'd14, 8'hFF); wr(5'd15, 8'hFF);
      for (int r = 0; r < 4; r++) wr(5'(24 + r), 8'hFF);
      #1;
      chk("R7 pads oe", pad_oe, NORM_OE);
      chk("R7 pads out", pad_out, NORM_OUT);
      chk_all_regs("R7 regs");
      rd_chk("R7 port3 read", 5'd24, 8'h00);
      rd_chk("R7 reg5 read", 5'd13, 8'h00);
      rd_chk("R7 pin C", 5'd20, 8'hA5);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_normal();
      t_sleep();
      t_sync();
      t_ignore();
      finish_run();
   end
endmodule